// File: doc/BRIEF.md
# Dual-Clock Burst-Addressed Shared RAM

This block is a true two-port synchronous memory. Port A and port B each run on their own clock. Either port may read or write any word of one shared array, and both may do so at the same time. Each port registers its address, write data and control lines on the rising edge of its clock. The registered address is held in a per-port burst counter. The counter can be cleared, loaded from the address pins, stepped by one, or held. This lets a port stream through consecutive words after a single address is presented.

Each port has a pair of selects, one active low and one active high. A port is selected only when both agree. A static mode pin picks how read data leaves the port. In flow-through mode the word appears in the cycle its address was registered. In pipelined mode it passes through one more output register first. The array depth and the word width are parameters. A register array models the storage.

Top module: `dpbr_top`

## Requirements
- R1: On reset, each port's burst counter is zero and its read-drive flag is low. Reset does not change the stored words. Each port has its own reset input, which is asserted asynchronously and released on that port's clock.
- R2: A word written through either port can be read back through either port. Two writes to different words, one through each port, both take effect.
- R3: A low `clr_n` at a rising edge sets the counter to zero. This takes priority over `load_n` and `step_n`.
- R4: A low `load_n` with a high `clr_n` loads the counter with the address pins. This takes priority over `step_n`.
- R5: A low `step_n` with `clr_n` and `load_n` high advances the counter by one. After word DEPTH-1 the counter goes to word 0.
- R6: With `clr_n`, `load_n` and `step_n` all high, the counter holds its value.
- R7: Flow-through mode is selected by `pipe_mode`=0. A read registered at edge k drives the word at the counter value from edge k, in the cycle after edge k. A write registered at edge k stores the data registered at edge k into that word.
- R8: Pipelined mode is selected by `pipe_mode`=1. A read registered at edge k drives its word only after edge k+1. A port coming from a deselected or write cycle therefore drives nothing in the first cycle after its first read edge.
- R9: The port is deselected when `sel_n` is 1 or `sel` is 0. A deselected cycle writes nothing and drives no read data.
- R10: `rdata_drv` is high only for a selected read cycle while `out_en_n` is 0. `out_en_n` acts without a clock edge. During write cycles `rdata_drv` stays low. When `rdata_drv` is low, `rdata` is high impedance.
- R11: All control inputs except `sel` and `pipe_mode` are active low. `wr_n`=0 requests a write and `wr_n`=1 requests a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| a_rst_n | input | 1 | Port A asynchronous reset, active low |
| a_sel_n | input | 1 | Port A select, active low |
| a_sel | input | 1 | Port A select, active high |
| a_wr_n | input | 1 | Port A write (0) or read (1) |
| a_out_en_n | input | 1 | Port A read-data enable, active low, unclocked |
| a_load_n | input | 1 | Port A counter load from address pins |
| a_step_n | input | 1 | Port A counter increment |
| a_clr_n | input | 1 | Port A counter clear |
| a_pipe_mode | input | 1 | Port A read path: 1 pipelined, 0 flow-through |
| a_addr | input | $clog2(DEPTH) | Port A address |
| a_wdata | input | WIDTH | Port A write data |
| a_rdata | output | WIDTH | Port A read data, high impedance when not driven |
| a_rdata_drv | output | 1 | Port A read data is being driven |
| b_clk | input | 1 | Port B clock |
| b_rst_n | input | 1 | Port B asynchronous reset, active low |
| b_sel_n | input | 1 | Port B select, active low |
| b_sel | input | 1 | Port B select, active high |
| b_wr_n | input | 1 | Port B write (0) or read (1) |
| b_out_en_n | input | 1 | Port B read-data enable, active low, unclocked |
| b_load_n | input | 1 | Port B counter load from address pins |
| b_step_n | input | 1 | Port B counter increment |
| b_clr_n | input | 1 | Port B counter clear |
| b_pipe_mode | input | 1 | Port B read path: 1 pipelined, 0 flow-through |
| b_addr | input | $clog2(DEPTH) | Port B address |
| b_wdata | input | WIDTH | Port B write data |
| b_rdata | output | WIDTH | Port B read data, high impedance when not driven |
| b_rdata_drv | output | 1 | Port B read data is being driven |

## Verification
The bench uses a 16-word array. Port A fills every word in one burst, and port B then reads a burst of 18 words on a slower clock. This separates a correct wrap from a counter that saturates or runs past the end, and it shows that the two ports share one array. A pipelined burst starting mid-array exposes an off-by-one latency, because each sample is expected to hold the word from the previous edge.

Cycles with clear, load and step asserted in combinations check the priority order and the hold case. Writes made while deselected by each select in turn must leave the word intact. Two overlapping bursts from both ports to disjoint words must both survive a final full sweep. A reset pulse on one port alone must zero its counter and keep the stored data.

// File: rtl/dpbr_pkg.sv
package dpbr_pkg;

  // Operation applied to a port's burst counter at a clock edge.
  typedef enum logic [1:0] {
    CNT_HOLD  = 2'd0,
    CNT_CLEAR = 2'd1,
    CNT_LOAD  = 2'd2,
    CNT_STEP  = 2'd3
  } cnt_op_e;

  // Priority: clear, then load, then step, otherwise hold.
  function automatic cnt_op_e pick_op(input logic clr_n, input logic load_n,
                                      input logic step_n);
    if (!clr_n)       return CNT_CLEAR;
    else if (!load_n) return CNT_LOAD;
    else if (!step_n) return CNT_STEP;
    else              return CNT_HOLD;
  endfunction

endpackage

// File: rtl/dpbr_rst_sync.sv
module dpbr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) chain_q <= '0;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_out_n = chain_q[STAGES-1];

endmodule

// File: rtl/dpbr_store.sv
// Shared array built from one bank per write port plus a per-word owner tag.
// Each tag array is written from a single clock. A word belongs to port A
// when the two tags differ and to port B when they are equal.
module dpbr_store #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             a_clk,
  input  logic             a_wr,
  input  logic [AW-1:0]    a_waddr,
  input  logic [WIDTH-1:0] a_wdata,
  input  logic [AW-1:0]    a_raddr,
  output logic [WIDTH-1:0] a_rdata,
  input  logic             b_clk,
  input  logic             b_wr,
  input  logic [AW-1:0]    b_waddr,
  input  logic [WIDTH-1:0] b_wdata,
  input  logic [AW-1:0]    b_raddr,
  output logic [WIDTH-1:0] b_rdata
);

  logic [WIDTH-1:0] bank_a [DEPTH];
  logic [WIDTH-1:0] bank_b [DEPTH];
  logic             tag_a  [DEPTH];
  logic             tag_b  [DEPTH];

  always_ff @(posedge a_clk) begin
    if (a_wr) begin
      bank_a[a_waddr] <= a_wdata;
      tag_a[a_waddr]  <= ~tag_b[a_waddr];
    end
  end

  always_ff @(posedge b_clk) begin
    if (b_wr) begin
      bank_b[b_waddr] <= b_wdata;
      tag_b[b_waddr]  <= tag_a[b_waddr];
    end
  end

  always_comb begin
    a_rdata = (tag_a[a_raddr] ^ tag_b[a_raddr]) ? bank_a[a_raddr] : bank_b[a_raddr];
    b_rdata = (tag_a[b_raddr] ^ tag_b[b_raddr]) ? bank_a[b_raddr] : bank_b[b_raddr];
  end

endmodule

// File: rtl/dpbr_port.sv
module dpbr_port
  import dpbr_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             sel,
  input  logic             wr_n,
  input  logic             out_en_n,
  input  logic             load_n,
  input  logic             step_n,
  input  logic             clr_n,
  input  logic             pipe_mode,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] arr_rdata,
  output logic             arr_wr,
  output logic [AW-1:0]    arr_addr,
  output logic [WIDTH-1:0] arr_wdata,
  output logic [AW-1:0]    cnt,
  output logic [WIDTH-1:0] rd_val,
  output logic             rd_drv
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  cnt_op_e          op;
  logic [AW-1:0]    cnt_d, cnt_q;
  logic             rd_d, wr_d;
  logic             rd_q, wr_q;
  logic [WIDTH-1:0] wdata_q;
  logic             pipe_rd_q;
  logic [WIDTH-1:0] pipe_dat_q;
  logic             drv_flow, drv_pipe;

  // Next state of the address/control stage.
  always_comb begin
    op = pick_op(clr_n, load_n, step_n);
    unique case (op)
      CNT_CLEAR: cnt_d = '0;
      CNT_LOAD:  cnt_d = addr;
      CNT_STEP:  cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      default:   cnt_d = cnt_q;
    endcase
    rd_d = !sel_n && sel && wr_n;
    wr_d = !sel_n && sel && !wr_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rd_q  <= 1'b0;
      wr_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rd_q  <= rd_d;
      wr_q  <= wr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_d) wdata_q <= wdata;
  end

  // Output register stage used in pipelined mode.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_rd_q <= 1'b0;
    else        pipe_rd_q <= rd_q;
  end

  always_ff @(posedge clk) begin
    if (rd_q) pipe_dat_q <= arr_rdata;
  end

  always_comb begin
    arr_wr    = wr_q;
    arr_addr  = cnt_q;
    arr_wdata = wdata_q;
    cnt       = cnt_q;
    drv_flow  = rd_q;
    drv_pipe  = pipe_rd_q;
    rd_val    = pipe_mode ? pipe_dat_q : arr_rdata;
    rd_drv    = !out_en_n && (pipe_mode ? drv_pipe : drv_flow);
  end

endmodule

// File: rtl/dpbr_top.sv
module dpbr_top #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             a_clk,
  input  logic             a_rst_n,
  input  logic             a_sel_n,
  input  logic             a_sel,
  input  logic             a_wr_n,
  input  logic             a_out_en_n,
  input  logic             a_load_n,
  input  logic             a_step_n,
  input  logic             a_clr_n,
  input  logic             a_pipe_mode,
  input  logic [AW-1:0]    a_addr,
  input  logic [WIDTH-1:0] a_wdata,
  output logic [WIDTH-1:0] a_rdata,
  output logic             a_rdata_drv,
  input  logic             b_clk,
  input  logic             b_rst_n,
  input  logic             b_sel_n,
  input  logic             b_sel,
  input  logic             b_wr_n,
  input  logic             b_out_en_n,
  input  logic             b_load_n,
  input  logic             b_step_n,
  input  logic             b_clr_n,
  input  logic             b_pipe_mode,
  input  logic [AW-1:0]    b_addr,
  input  logic [WIDTH-1:0] b_wdata,
  output logic [WIDTH-1:0] b_rdata,
  output logic             b_rdata_drv
);

  logic             a_rst_s, b_rst_s;
  logic             a_wr, b_wr;
  logic [AW-1:0]    a_waddr, b_waddr;
  logic [WIDTH-1:0] a_arr_wd, b_arr_wd;
  logic [WIDTH-1:0] a_arr_rd, b_arr_rd;
  logic [AW-1:0]    a_cnt, b_cnt;
  logic [WIDTH-1:0] a_val, b_val;

  dpbr_rst_sync u_rs_a (.clk(a_clk), .rst_in_n(a_rst_n), .rst_out_n(a_rst_s));
  dpbr_rst_sync u_rs_b (.clk(b_clk), .rst_in_n(b_rst_n), .rst_out_n(b_rst_s));

  dpbr_port #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_port_a (
    .clk(a_clk), .rst_n(a_rst_s), .sel_n(a_sel_n), .sel(a_sel), .wr_n(a_wr_n),
    .out_en_n(a_out_en_n), .load_n(a_load_n), .step_n(a_step_n), .clr_n(a_clr_n),
    .pipe_mode(a_pipe_mode), .addr(a_addr), .wdata(a_wdata), .arr_rdata(a_arr_rd),
    .arr_wr(a_wr), .arr_addr(a_waddr), .arr_wdata(a_arr_wd), .cnt(a_cnt),
    .rd_val(a_val), .rd_drv(a_rdata_drv)
  );

  dpbr_port #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_port_b (
    .clk(b_clk), .rst_n(b_rst_s), .sel_n(b_sel_n), .sel(b_sel), .wr_n(b_wr_n),
    .out_en_n(b_out_en_n), .load_n(b_load_n), .step_n(b_step_n), .clr_n(b_clr_n),
    .pipe_mode(b_pipe_mode), .addr(b_addr), .wdata(b_wdata), .arr_rdata(b_arr_rd),
    .arr_wr(b_wr), .arr_addr(b_waddr), .arr_wdata(b_arr_wd), .cnt(b_cnt),
    .rd_val(b_val), .rd_drv(b_rdata_drv)
  );

  dpbr_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .a_clk(a_clk), .a_wr(a_wr), .a_waddr(a_waddr), .a_wdata(a_arr_wd),
    .a_raddr(a_cnt), .a_rdata(a_arr_rd),
    .b_clk(b_clk), .b_wr(b_wr), .b_waddr(b_waddr), .b_wdata(b_arr_wd),
    .b_raddr(b_cnt), .b_rdata(b_arr_rd)
  );

  assign a_rdata = a_rdata_drv ? a_val : 'z;
  assign b_rdata = b_rdata_drv ? b_val : 'z;

endmodule

// File: rtl/dpbr_chk.sv
module dpbr_chk #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel_n,
  input logic          sel,
  input logic          wr_n,
  input logic          out_en_n,
  input logic          load_n,
  input logic          step_n,
  input logic          clr_n,
  input logic          pipe_mode,
  input logic [AW-1:0] addr,
  input logic [AW-1:0] cnt,
  input logic          drv
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> cnt == '0);

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !load_n) |=> cnt == $past(addr));

  assert_step_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && !step_n) |=>
      cnt == (($past(cnt) == LAST) ? '0 : AW'($past(cnt) + 1'b1)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && step_n) |=> $stable(cnt));

  assert_pipe_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && $past(sel_n || !sel || !wr_n, 2)) |-> !drv);

  assert_desel_nodrive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n || !sel) |=> (pipe_mode || !drv));

  assert_write_nodrive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && sel && !wr_n) |=> (pipe_mode || !drv));

  assert_outen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !drv);

endmodule

bind dpbr_top dpbr_chk #(.DEPTH(DEPTH)) u_chk_a (
  .clk(a_clk), .rst_n(a_rst_s), .sel_n(a_sel_n), .sel(a_sel), .wr_n(a_wr_n),
  .out_en_n(a_out_en_n), .load_n(a_load_n), .step_n(a_step_n), .clr_n(a_clr_n),
  .pipe_mode(a_pipe_mode), .addr(a_addr), .cnt(a_cnt), .drv(a_rdata_drv)
);

bind dpbr_top dpbr_chk #(.DEPTH(DEPTH)) u_chk_b (
  .clk(b_clk), .rst_n(b_rst_s), .sel_n(b_sel_n), .sel(b_sel), .wr_n(b_wr_n),
  .out_en_n(b_out_en_n), .load_n(b_load_n), .step_n(b_step_n), .clr_n(b_clr_n),
  .pipe_mode(b_pipe_mode), .addr(b_addr), .cnt(b_cnt), .drv(b_rdata_drv)
);

// File: tb/tb_dpbr_top.sv
module tb_dpbr_top;

  localparam int CLK_PERIOD = 10;
  localparam int B_PERIOD   = CLK_PERIOD + 4;
  localparam int DEPTH      = 16;
  localparam int WIDTH      = 8;
  localparam int AW         = $clog2(DEPTH);

  logic a_clk = 1'b0;
  logic b_clk = 1'b0;
  always #(CLK_PERIOD/2) a_clk = ~a_clk;
  always #(B_PERIOD/2)   b_clk = ~b_clk;

  logic a_rst_n, b_rst_n;
  logic sel_n [2], sel [2], wr_n [2], oen [2], ld_n [2], st_n [2], cl_n [2], pm [2];
  logic [AW-1:0]    ad [2];
  logic [WIDTH-1:0] wd [2];
  wire  [WIDTH-1:0] a_rdata, b_rdata;
  logic             a_drv, b_drv;

  logic [WIDTH-1:0] mem_m [DEPTH];
  int checks = 0;
  int errors = 0;

  dpbr_top #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
    .a_clk(a_clk), .a_rst_n(a_rst_n), .a_sel_n(sel_n[0]), .a_sel(sel[0]),
    .a_wr_n(wr_n[0]), .a_out_en_n(oen[0]), .a_load_n(ld_n[0]), .a_step_n(st_n[0]),
    .a_clr_n(cl_n[0]), .a_pipe_mode(pm[0]), .a_addr(ad[0]), .a_wdata(wd[0]),
    .a_rdata(a_rdata), .a_rdata_drv(a_drv),
    .b_clk(b_clk), .b_rst_n(b_rst_n), .b_sel_n(sel_n[1]), .b_sel(sel[1]),
    .b_wr_n(wr_n[1]), .b_out_en_n(oen[1]), .b_load_n(ld_n[1]), .b_step_n(st_n[1]),
    .b_clr_n(cl_n[1]), .b_pipe_mode(pm[1]), .b_addr(ad[1]), .b_wdata(wd[1]),
    .b_rdata(b_rdata), .b_rdata_drv(b_drv)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [WIDTH-1:0] dq(input int p);
    return (p == 0) ? a_rdata : b_rdata;
  endfunction

  function automatic logic drv(input int p);
    return (p == 0) ? a_drv : b_drv;
  endfunction

  task automatic align(input int p);
    if (p == 0) @(negedge a_clk); else @(negedge b_clk);
  endtask

  // one rising edge, then sample point at the following falling edge
  task automatic tick(input int p);
    if (p == 0) begin @(posedge a_clk); @(negedge a_clk); end
    else        begin @(posedge b_clk); @(negedge b_clk); end
  endtask

  task automatic drive(input int p, input logic s_n, input logic s, input logic w_n,
                       input logic l_n, input logic t_n, input logic c_n,
                       input logic [AW-1:0] a, input logic [WIDTH-1:0] d);
    sel_n[p] = s_n; sel[p] = s; wr_n[p] = w_n;
    ld_n[p] = l_n; st_n[p] = t_n; cl_n[p] = c_n; ad[p] = a; wd[p] = d;
  endtask

  task automatic idle(input int p);
    drive(p, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0);
  endtask

  task automatic burst_write(input int p, input int start, input int n, input int seed);
    align(p);
    pm[p] = 1'b0;
    for (int i = 0; i < n; i++) begin
      logic [WIDTH-1:0] v;
      int w;
      w = (start + i) % DEPTH;
      v = WIDTH'(w * 29 + seed);
      drive(p, 1'b0, 1'b1, 1'b0, (i == 0) ? 1'b0 : 1'b1, (i == 0) ? 1'b1 : 1'b0,
            1'b1, AW'(start), v);
      mem_m[w] = v;
      tick(p);
      chk("R10 no drive during write", 32'(drv(p)), 32'd0);
    end
    idle(p);
    tick(p);
  endtask

  task automatic read_flow(input int p, input int start, input int n);
    align(p);
    pm[p] = 1'b0;
    drive(p, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, AW'(start), '0);
    tick(p);
    chk("R7 flow drive", 32'(drv(p)), 32'd1);
    chk("R7 R2 flow first word", 32'(dq(p)), 32'(mem_m[start % DEPTH]));
    for (int i = 1; i < n; i++) begin
      drive(p, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, '0, '0);
      tick(p);
      chk("R5 R7 flow burst word", 32'(dq(p)), 32'(mem_m[(start + i) % DEPTH]));
    end
    idle(p);
    tick(p);
  endtask

  task automatic read_pipe(input int p, input int start, input int n);
    align(p);
    pm[p] = 1'b1;
    for (int c = 0; c < n; c++) begin
      if (c == 0) drive(p, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, AW'(start), '0);
      else        drive(p, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, '0, '0);
      tick(p);
      if (c == 0) chk("R8 pipe not yet driving", 32'(drv(p)), 32'd0);
      else begin
        chk("R8 pipe driving", 32'(drv(p)), 32'd1);
        chk("R8 pipe word", 32'(dq(p)), 32'(mem_m[(start + c - 1) % DEPTH]));
      end
    end
    idle(p);
    tick(p);
    chk("R8 pipe last word", 32'(dq(p)), 32'(mem_m[(start + n - 1) % DEPTH]));
    tick(p);
    chk("R8 pipe drive drops", 32'(drv(p)), 32'd0);
    pm[p] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge a_clk);
    errors++;
    $display("FAIL watchdog: actual still running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    a_rst_n = 1'b0;
    b_rst_n = 1'b0;
    for (int p = 0; p < 2; p++) begin
      idle(p);
      oen[p] = 1'b0;
      pm[p]  = 1'b0;
    end
    repeat (3) @(negedge b_clk);
    a_rst_n = 1'b1;
    b_rst_n = 1'b1;
    repeat (4) @(negedge b_clk);
    chk("R1 reset drive A", 32'(a_drv), 32'd0);
    chk("R1 reset drive B", 32'(b_drv), 32'd0);

    // R2: fill through A, sweep through B past the end (R5 wrap)
    burst_write(0, 0, DEPTH, 7);
    read_flow(1, 0, DEPTH + 2);

    // R8 pipelined burst from mid-array across the wrap
    read_pipe(0, 13, 6);

    // R9 deselected writes leave word 3 unchanged
    align(0);
    drive(0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, AW'(3), 8'hEE);
    tick(0);
    chk("R9 deselect by sel_n no drive", 32'(a_drv), 32'd0);
    drive(0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, AW'(3), 8'hDD);
    tick(0);
    chk("R9 deselect by sel no drive", 32'(a_drv), 32'd0);
    idle(0);
    tick(0);
    read_flow(0, 3, 1);

    // R3 R4 R6 priority and hold on port B
    align(1);
    drive(1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, AW'(9), '0);
    tick(1);
    chk("R3 clear beats load", 32'(b_rdata), 32'(mem_m[0]));
    drive(1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, AW'(9), '0);
    tick(1);
    chk("R4 load beats step", 32'(b_rdata), 32'(mem_m[9]));
    drive(1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0);
    tick(1);
    chk("R6 hold", 32'(b_rdata), 32'(mem_m[9]));
    tick(1);
    chk("R6 hold again", 32'(b_rdata), 32'(mem_m[9]));
    drive(1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0, '0);
    tick(1);
    chk("R3 clear beats step", 32'(b_rdata), 32'(mem_m[0]));
    idle(1);
    tick(1);

    // R10 unclocked output enable; R11 polarity of out_en_n
    align(0);
    drive(0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, AW'(4), '0);
    oen[0] = 1'b1;
    tick(0);
    chk("R10 R11 out_en_n high no drive", 32'(a_drv), 32'd0);
    oen[0] = 1'b0;
    #1;
    chk("R10 out_en_n low drives at once", 32'(a_drv), 32'd1);
    chk("R10 word after enable", 32'(a_rdata), 32'(mem_m[4]));
    idle(0);
    tick(0);

    // R2 overlapping bursts from both ports to disjoint words
    fork
      burst_write(0, 2, 3, 64);
      burst_write(1, 9, 3, 128);
    join
    read_flow(0, 0, DEPTH);

    // R1 reset of port B alone clears its counter, keeps data
    align(1);
    b_rst_n = 1'b0;
    tick(1);
    chk("R1 reset drive B", 32'(b_drv), 32'd0);
    b_rst_n = 1'b1;
    tick(1);
    tick(1);
    tick(1);
    drive(1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0);
    tick(1);
    chk("R1 counter zero after reset", 32'(b_rdata), 32'(mem_m[0]));
    idle(1);
    tick(1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule